// File: doc/BRIEF.md
# Seconds Counter with Alarm Interrupt

This core keeps a running count of seconds for a larger system. A 1 Hz tick input, made elsewhere and already in the core's clock domain, advances a 32-bit counter. The counter only moves while a run bit in the control word is set. Software reads the live count, writes a new count, and programs a match value through a simple single-cycle 32-bit register bus. A read returns data combinationally in the same cycle. A write takes effect at the next clock edge.

When a tick brings the counter onto the match value, a sticky alarm flag is raised. The flag stays set until software clears it by writing a 1 to bit 0 of the clear register. A mask register selects whether the flag drives the interrupt line. The masked view can be read at its own offset. Software keeps the alarm apart from the counter by reading the raw and masked views separately.

Top module: `rtc_sec_core`

## Requirements
- R1: After reset, the count, match, control, mask, raw-status and masked-status reads all return 0, and `irq` is low.
- R2: A write to the load register (offset 0x08) replaces the count at the next edge. The data register (offset 0x00) returns the live count. The match register is at offset 0x04.
- R3: While control bit 26 (offset 0x0C) is 1, each cycle with `tick_1hz` high advances the count by one.
- R4: While control bit 26 is 0, ticks leave the count unchanged.
- R5: Raw-status bit 0 (offset 0x14) is set on the tick that brings the count equal to the match value. It stays set after the count moves past the match.
- R6: Writing 1 to bit 0 of the clear register (offset 0x1C) clears raw-status bit 0. Writing 0 there has no effect.
- R7: Masked status (offset 0x18) equals raw status AND mask, where the mask is at offset 0x10, bit 0. `irq` is high exactly when the masked status is non-zero.
- R8: If a clear write and a match-setting tick occur in the same cycle, the raw-status bit ends set.
- R9: If a load write and a tick occur in the same cycle, the loaded value is taken and no increment happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr` |
| irq | output | 1 | Alarm interrupt, high while masked status is set |

## Verification
The counter is driven with ticks while stopped, with ticks while running, and with a tick that coincides with a load. Together these separate the enable gating from the increment and from load priority. The alarm is approached one tick at a time and then passed. This shows that the flag is raised exactly on arrival and that it is sticky. Clear writes of 0 and of 1, mask on and off, and a clear that collides with a match tell the clear, mask and priority paths apart.

// File: rtl/rtc_sec_core.sv
module rtc_sec_core #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int RUN_BIT = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_MTCH = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(5'h14);
  localparam logic [ADDR_W-1:0] A_MSK  = ADDR_W'(5'h18);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(5'h1C);

  logic [DATA_W-1:0] count, match;
  logic run, mask, raw;

  wire wr   = req_valid & req_write;
  wire ld   = wr && (req_addr == A_LOAD);
  wire step = tick_1hz & run & ~ld;
  wire hit  = step && ((count + 1'b1) == match);
  wire clr  = wr && (req_addr == A_CLR) && req_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      match <= '0;
      run   <= 1'b0;
      mask  <= 1'b0;
      raw   <= 1'b0;
    end else begin
      if (ld) count <= req_wdata;
      else if (step) count <= count + 1'b1;
      if (wr && req_addr == A_MTCH) match <= req_wdata;
      if (wr && req_addr == A_CTRL) run <= req_wdata[RUN_BIT];
      if (wr && req_addr == A_MASK) mask <= req_wdata[0];
      if (hit) raw <= 1'b1;
      else if (clr) raw <= 1'b0;
    end
  end

  assign irq = raw & mask;

  always_comb begin
    rd_data = '0;
    case (req_addr)
      A_CNT:  rd_data = count;
      A_MTCH: rd_data = match;
      A_CTRL: rd_data[RUN_BIT] = run;
      A_MASK: rd_data[0] = mask;
      A_RAW:  rd_data[0] = raw;
      A_MSK:  rd_data[0] = raw & mask;
      default: rd_data = '0;
    endcase
  end

  // R3
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && run && !ld) |=> count == $past(count) + 1'b1);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld) |=> $stable(count));
  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> count == $past(req_wdata));
  // R5
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !clr) |=> raw);
  // R8
  setwins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !raw);
endmodule

// File: tb/sim_rtc_sec_core.sv
`timescale 1ns/1ps
module sim_rtc_sec_core;
  logic clk = 0, rst_n = 0, tick = 0, vld = 0, we = 0;
  logic [4:0] addr = 0;
  logic [31:0] wd = 0, rd;
  logic irq;
  int nvec = 0, nbad = 0;
  bit done = 0;

  rtc_sec_core u0 (.clk(clk), .rst_n(rst_n), .tick_1hz(tick), .req_valid(vld),
    .req_write(we), .req_addr(addr), .req_wdata(wd), .rd_data(rd), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(bit t, bit v, bit w, logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    tick = t; vld = v; we = w; addr = a; wd = d;
    @(negedge clk);
    tick = 0; vld = 0; we = 0;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d); cyc(0, 1, 1, a, d); endtask
  task automatic tk(); cyc(1, 0, 0, 0, 0); endtask

  task automatic rdchk(string tag, logic [4:0] a, logic [31:0] exp);
    addr = a; #1;
    chk(tag, rd, exp);
  endtask

  task automatic t_reset();
    rdchk("R1 count", 5'h00, 0);
    rdchk("R1 match", 5'h04, 0);
    rdchk("R1 ctrl", 5'h0C, 0);
    rdchk("R1 mask", 5'h10, 0);
    rdchk("R1 raw", 5'h14, 0);
    rdchk("R1 masked", 5'h18, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_count();
    wr(5'h08, 100);
    rdchk("R2 load", 5'h00, 100);
    tk(); tk();
    rdchk("R4 stopped", 5'h00, 100);
    wr(5'h0C, 32'h1 << 26);
    rdchk("R3 ctrl readback", 5'h0C, 32'h1 << 26);
    tk(); tk(); tk();
    rdchk("R3 three ticks", 5'h00, 103);
    cyc(1, 1, 1, 5'h08, 500);
    rdchk("R9 load beats tick", 5'h00, 500);
    tk();
    rdchk("R3 after load", 5'h00, 501);
  endtask

  task automatic t_alarm();
    wr(5'h08, 10);
    wr(5'h04, 12);
    rdchk("R2 match readback", 5'h04, 12);
    tk();
    rdchk("R5 before match", 5'h14, 0);
    tk();
    rdchk("R5 on match", 5'h14, 1);
    tk();
    rdchk("R5 sticky", 5'h14, 1);
    rdchk("R7 masked off", 5'h18, 0);
    chk("R7 irq off", {31'b0, irq}, 0);
    wr(5'h10, 1);
    rdchk("R7 masked on", 5'h18, 1);
    chk("R7 irq on", {31'b0, irq}, 1);
    wr(5'h1C, 0);
    rdchk("R6 zero write ignored", 5'h14, 1);
    wr(5'h1C, 1);
    rdchk("R6 cleared", 5'h14, 0);
    chk("R6 irq dropped", {31'b0, irq}, 0);
  endtask

  task automatic t_setwins();
    wr(5'h08, 20);
    wr(5'h04, 21);
    cyc(1, 1, 1, 5'h1C, 1);
    rdchk("R8 set wins", 5'h14, 1);
    chk("R8 irq", {31'b0, irq}, 1);
    wr(5'h10, 0);
    chk("R7 mask removed", {31'b0, irq}, 0);
    wr(5'h1C, 1);
    rdchk("R6 final clear", 5'h14, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_count();
    t_alarm();
    t_setwins();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule